// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write port and its read port run on clocks that need not be related. A write is qualified by a pair of enables and a read by a pair of enables. Four active-low status outputs report the fill state. Empty and a configurable almost-empty threshold are produced on the read clock. Full and a configurable almost-full threshold are produced on the write clock.

A shared input `wen2_ld` has two possible roles. The block captures it while reset is held. If it is captured HIGH, it acts as a second write enable, which allows depth cascading. If it is captured LOW, it marks cycles that belong to the threshold-offset registers. A companion sequencer, outside this block, drives those offset cycles and presents the new offsets on `ofs_we`.

The read side holds the last word read in an output register. The data bus is paired with an output-enable qualifier instead of a three-state driver.

Top module: `dcfifo9_pflag`

## Requirements
- R1: Words read out come in the order they were written, 9 bits wide. The capacity is the parameter DEPTH, one of 256, 512, 1024, 2048 or 4096.
- R2: The block samples `wen2_ld` on every write-clock edge while `rst_n` is LOW. A captured 1 selects dual-enable mode. A captured 0 selects programmable-offset mode. The mode then holds until the next reset.
- R3: A word is stored on a rising `wclk` edge only when `wen1_n`=0 and `wen2_ld`=1. This holds in both modes. In programmable-offset mode, a cycle with `wen2_ld`=0 stores no data.
- R4: A rising `rclk` edge moves the next word into `dout` only when `ren1_n`=0 and `ren2_n`=0. With either enable HIGH, `dout` holds its value and the stored words are not consumed.
- R5: While `full_n`=0, writes are discarded. While `empty_n`=0, reads are discarded and `dout` holds its value.
- R6: Reset (synchronous, `rst_n` LOW) puts the block in a defined state:
  - both pointers return to the first location;
  - `dout` becomes 0;
  - `full_n` and `afull_n` become 1;
  - `empty_n` and `aempty_n` become 0;
  - both offsets become 7.
- R7: `full_n` is 0 exactly when DEPTH words are held. `afull_n` is 0 when DEPTH−m or more words are held, where m is the full offset.
- R8: `empty_n` is 0 when no word is held. `aempty_n` is 0 when n or fewer words are held, where n is the empty offset.
- R9: In programmable-offset mode, a write-clock edge with `ofs_we`=1 loads `ae_ofs` as n and `af_ofs` as m. In dual-enable mode, `ofs_we` is ignored and both offsets stay at 7.
- R10: `dout_en` is the inverse of `oe_n`. The output register keeps being updated whatever `oe_n` is.
- R11: A flag is never late to become active. Once the other side has stopped moving, each flag reaches its settled value within SYNC_STAGES+1 edges of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, independent of wclk |
| rst_n | input | 1 | Synchronous reset, active LOW; must span several edges of both clocks |
| din | input | DW | Write data |
| wen1_n | input | 1 | Write enable, active LOW |
| wen2_ld | input | 1 | Second write enable (active HIGH), or offset-cycle marker; role captured at reset |
| ren1_n | input | 1 | First read enable, active LOW |
| ren2_n | input | 1 | Second read enable, active LOW |
| oe_n | input | 1 | Output enable, active LOW |
| ofs_we | input | 1 | Offset load strobe from the offset sequencer (write clock) |
| ae_ofs | input | log2(DEPTH) | New almost-empty offset n |
| af_ofs | input | log2(DEPTH) | New almost-full offset m |
| dout | output | DW | Output register |
| dout_en | output | 1 | HIGH when dout is to be driven |
| empty_n | output | 1 | Empty flag, active LOW, read clock |
| aempty_n | output | 1 | Almost-empty flag, active LOW, read clock |
| full_n | output | 1 | Full flag, active LOW, write clock |
| afull_n | output | 1 | Almost-full flag, active LOW, write clock |

## Verification
The hardest cases to reach are the edge where a threshold flag toggles and the point where a write is turned away because the buffer is full. Both have to be seen under clock ratios that are related and under ratios that are not. The stimulus reaches them through a table of write and read bursts. The bursts walk the fill level across each offset boundary and push past the full point while the other side is idle. Each flag is then compared with the level implied by the table. The offset-cycle marker in programmable mode is checked one word below the almost-full boundary. A write that slipped through would flip `afull_n` there, so the stray write is caught at the ports.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int PTR_MAX = 13;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance head-tail modulo 2**pw
  function automatic ptr_t occupancy(ptr_t head, ptr_t tail, int unsigned pw);
    ptr_t d;
    d = head - tail;
    return d & ((ptr_t'(1) << pw) - ptr_t'(1));
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo9_pflag.sv
module dcfifo9_pflag #(
  parameter int DEPTH       = 256,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_DEFAULT = 7
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic [DW-1:0]            din,
  input  logic                     wen1_n,
  input  logic                     wen2_ld,
  input  logic                     ren1_n,
  input  logic                     ren2_n,
  input  logic                     oe_n,
  input  logic                     ofs_we,
  input  logic [$clog2(DEPTH)-1:0] ae_ofs,
  input  logic [$clog2(DEPTH)-1:0] af_ofs,
  output logic [DW-1:0]            dout,
  output logic                     dout_en,
  output logic                     empty_n,
  output logic                     aempty_n,
  output logic                     full_n,
  output logic                     afull_n
);
  import dcf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [AW-1:0] OFS_RST  = AW'(OFS_DEFAULT);

  // ---------------- write-clock domain ----------------
  logic          mode_prog;   // 1: programmable-offset mode
  logic [PW-1:0] wbin, wgray, wbin_nx, rgray_s, wr_level, wlvl_nx;
  logic [AW-1:0] ae_q, af_q;
  logic          wr_fire, ofs_take;

  always_ff @(posedge wclk) begin
    if (!rst_n) mode_prog <= ~wen2_ld;
  end

  assign wr_fire  = rst_n & ~wen1_n & wen2_ld & full_n;
  assign ofs_take = rst_n & mode_prog & ofs_we;
  assign wbin_nx  = wbin + PW'(wr_fire);
  assign wr_level = PW'(occupancy(ptr_t'(wbin), from_gray(ptr_t'(rgray_s)), PW));
  assign wlvl_nx  = PW'(occupancy(ptr_t'(wbin_nx), from_gray(ptr_t'(rgray_s)), PW));

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      ae_q    <= OFS_RST;
      af_q    <= OFS_RST;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= PW'(to_gray(ptr_t'(wbin_nx)));
      if (ofs_take) begin
        ae_q <= ae_ofs;
        af_q <= af_ofs;
      end
      full_n  <= (wlvl_nx != FULL_LVL);
      afull_n <= (wlvl_nx <  (FULL_LVL - PW'(af_q)));
    end
  end

  // ---------------- storage ----------------
  logic [PW-1:0] rbin, rgray, rbin_nx, wgray_s, rd_level, rlvl_nx;
  logic [DW-1:0] ram_q, dout_q;
  logic          rd_fire;

  dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk (wclk),
    .we   (wr_fire),
    .waddr(wbin[AW-1:0]),
    .wdata(din),
    .raddr(rbin[AW-1:0]),
    .rdata(ram_q)
  );

  // ---------------- pointer crossings ----------------
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  // ---------------- read-clock domain ----------------
  assign rd_fire  = rst_n & ~ren1_n & ~ren2_n & empty_n;
  assign rbin_nx  = rbin + PW'(rd_fire);
  assign rd_level = PW'(occupancy(from_gray(ptr_t'(wgray_s)), ptr_t'(rbin), PW));
  assign rlvl_nx  = PW'(occupancy(from_gray(ptr_t'(wgray_s)), ptr_t'(rbin_nx), PW));

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      dout_q   <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= PW'(to_gray(ptr_t'(rbin_nx)));
      if (rd_fire) dout_q <= ram_q;
      empty_n  <= (rlvl_nx != '0);
      aempty_n <= (rlvl_nx >  PW'(ae_q));  // ae_q is quasi-static configuration
    end
  end

  assign dout    = dout_q;
  assign dout_en = ~oe_n;
endmodule

// File: rtl/dcfifo9_pflag_chk.sv
module dcfifo9_pflag_chk #(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          mode_prog,
  input logic          rd_fire,
  input logic [PW-1:0] wr_level,
  input logic [PW-1:0] rd_level,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [DW-1:0] dout
);
  // R5
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= PW'(DEPTH));

  // R5
  no_underflow_view_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_level <= PW'(DEPTH));

  // R7
  full_flag_at_depth_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_level == PW'(DEPTH)) |-> !full_n);

  // R8
  empty_flag_at_zero_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_level == '0) |-> !empty_n);

  // R4
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_fire |=> $stable(dout));

  // R2
  mode_fixed_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    rst_n |=> $stable(mode_prog));

  // R6
  wr_reset_state_chk: assert property (@(posedge wclk)
    !rst_n |=> (full_n && afull_n));

  // R6
  rd_reset_state_chk: assert property (@(posedge rclk)
    !rst_n |=> (!empty_n && !aempty_n && dout == '0));
endmodule

bind dcfifo9_pflag dcfifo9_pflag_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .rst_n    (rst_n),
  .mode_prog(mode_prog),
  .rd_fire  (rd_fire),
  .wr_level (wr_level),
  .rd_level (rd_level),
  .full_n   (full_n),
  .afull_n  (afull_n),
  .empty_n  (empty_n),
  .aempty_n (aempty_n),
  .dout     (dout)
);

// File: tb/test_dcfifo9_pflag.sv
`timescale 1ns/1ps
module test_dcfifo9_pflag;
  localparam int DEPTH  = 256;
  localparam int AW     = 8;
  localparam int SETTLE = 6;
  localparam int NV     = 11;
  // writes, reads, expected occupancy afterwards
  localparam int VEC [NV][3] = '{
    '{3, 0, 3}, '{5, 0, 8}, '{0, 1, 7}, '{0, 7, 0}, '{0, 2, 0},
    '{248, 0, 248}, '{1, 0, 249}, '{7, 0, 256}, '{2, 0, 256},
    '{0, 1, 255}, '{0, 255, 0}
  };

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [8:0] din = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0, ofs_we = 0;
  logic [AW-1:0] ae_ofs = '0, af_ofs = '0;
  logic [8:0] dout;
  logic dout_en, empty_n, aempty_n, full_n, afull_n;

  realtime rhalf = 20.0;
  always #10 wclk = ~wclk;
  initial forever #(rhalf) rclk = ~rclk;

  dcfifo9_pflag #(.DEPTH(DEPTH)) i_dcfifo9_pflag (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .ofs_we(ofs_we), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout),
    .dout_en(dout_en), .empty_n(empty_n), .aempty_n(aempty_n),
    .full_n(full_n), .afull_n(afull_n)
  );

  int total = 0, bad = 0;
  int q[$];
  int n_ofs = 7, m_ofs = 7;
  logic [8:0] wdat = '0;
  int exp_dout = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(string req, int cnt);
    repeat (SETTLE) @(posedge rclk);
    repeat (SETTLE) @(posedge wclk);
    @(negedge rclk);
    chk({req, " empty_n"},  empty_n,  int'(cnt != 0));
    chk({req, " aempty_n"}, aempty_n, int'(cnt > n_ofs));
    @(negedge wclk);
    chk({req, " full_n"},   full_n,   int'(cnt != DEPTH));
    chk({req, " afull_n"},  afull_n,  int'(cnt < DEPTH - m_ofs));
  endtask

  task automatic push(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk); din = wdat; wen1_n = 0;
      @(negedge wclk); wen1_n = 1;
      if (q.size() < DEPTH) q.push_back(int'(wdat));
      wdat = wdat + 9'd1;
    end
  endtask

  task automatic pop(int k, string req);
    for (int i = 0; i < k; i++) begin
      @(negedge rclk); ren1_n = 0; ren2_n = 0;
      @(negedge rclk); ren1_n = 1; ren2_n = 1;
      if (q.size() > 0) exp_dout = q.pop_front();
      chk(req, int'(dout), exp_dout);
    end
  endtask

  task automatic do_reset(logic ld);
    @(negedge wclk);
    rst_n = 0; wen2_ld = ld; wen1_n = 1; ren1_n = 1; ren2_n = 1; ofs_we = 0;
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    @(negedge wclk); rst_n = 1; wen2_ld = 1;
    q.delete(); exp_dout = 0; n_ofs = 7; m_ofs = 7;
  endtask

  task automatic run_table();
    for (int v = 0; v < NV; v++) begin
      push(VEC[v][0]);
      pop(VEC[v][1], "R1 R5 data order / held output");
      check_flags("R7 R8 R11 table", VEC[v][2]);
    end
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Phase A: related clocks, read clock half the write rate, dual-enable mode
    rhalf = 20.0;
    do_reset(1'b1);
    @(negedge rclk);
    chk("R6 dout after reset", int'(dout), 0);
    check_flags("R6 reset flags", 0);
    run_table();

    // R3: second enable LOW blocks the write
    @(negedge wclk); wen2_ld = 0; wen1_n = 0; din = 9'h1AA;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    check_flags("R3 wen2 low no write", 0);

    // R9/R2: offset strobe ignored in dual-enable mode
    @(negedge wclk); ae_ofs = 8'd20; af_ofs = 8'd20; ofs_we = 1;
    @(negedge wclk); ofs_we = 0;
    push(8);
    check_flags("R9 R2 offsets stay 7", 8);

    // R4: only one read enable active
    @(negedge rclk); ren1_n = 0; ren2_n = 1;
    @(negedge rclk); ren1_n = 1;
    chk("R4 ren2 high holds dout", int'(dout), exp_dout);
    @(negedge rclk); ren1_n = 1; ren2_n = 0;
    @(negedge rclk); ren2_n = 1;
    chk("R4 ren1 high holds dout", int'(dout), exp_dout);
    check_flags("R4 nothing consumed", 8);
    pop(1, "R4 first word still next");

    // R10
    @(negedge rclk); oe_n = 1;
    @(negedge rclk); chk("R10 dout_en low", dout_en, 0);
    pop(1, "R10 register updates while disabled");
    oe_n = 0;
    @(negedge rclk); chk("R10 dout_en high", dout_en, 1);
    pop(6, "R1 drain");
    check_flags("R8 drained", 0);

    // Phase B: unrelated clocks
    rhalf = 13.5;
    do_reset(1'b1);
    @(negedge rclk);
    chk("R6 dout after second reset", int'(dout), 0);
    run_table();

    // Phase C: programmable-offset mode
    rhalf = 10.0;
    do_reset(1'b0);
    check_flags("R6 prog reset", 0);
    push(7);
    check_flags("R8 R6 default n=7 at 7", 7);
    push(1);
    check_flags("R8 default n=7 at 8", 8);
    @(negedge wclk); ae_ofs = 8'd3; af_ofs = 8'd10; ofs_we = 1;
    @(negedge wclk); ofs_we = 0;
    n_ofs = 3; m_ofs = 10;
    check_flags("R9 R2 offsets loaded", 8);
    pop(4, "R1 prog mode");
    check_flags("R8 n=3 at 4", 4);
    pop(1, "R1 prog mode");
    check_flags("R8 n=3 at 3", 3);
    push(242);
    check_flags("R7 m=10 at 245", 245);
    @(negedge wclk); wen2_ld = 0; wen1_n = 0; din = 9'h155;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    check_flags("R3 R2 load cycle stores nothing", 245);
    push(1);
    check_flags("R7 m=10 at 246", 246);
    pop(246, "R1 prog drain");
    check_flags("R8 prog drained", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule